// File: doc/BRIEF.md
# Flash Command Sequence Decoder

This block sits behind the bus front end of a byte-wide flash controller and watches every write cycle that reaches it. Bus writes arrive as a single-cycle synchronous strobe with a 20-bit address and an 8-bit data byte. Edge latching and glitch rejection on the chip-select and write-strobe pins are done before this block. A multi-cycle command is accepted only when it opens with the two-write unlock prefix. The block then recognises byte program, whole-array erase, boot-region lock, and entry to or exit from identification mode.

When a command completes, the block raises a one-cycle start pulse for the array sequencer. For byte program it also presents the target address and data. In identification mode, a read strobe at address 0 or 1 returns the vendor code or the part code. While the array sequencer reports busy, write cycles are dropped and the decode state is held.

Top module: `flash_cmd_decoder`

## Requirements
- R1: After reset, and after any assertion of `rst_ni`, the decoder is idle, `id_mode_o` is 0 and no start pulse is high. A sequence that was interrupted by reset does not complete.
- R2: The writes AA@5555, 55@2AAA and A0@5555, followed by any write A@D, raise `prog_start_o` for one cycle, in the cycle after that fourth write. In that cycle `prog_addr_o`=A and `prog_data_o`=D.
- R3: The writes AA@5555, 55@2AAA, 80@5555, AA@5555, 55@2AAA and 10@5555 raise `erase_start_o` for one cycle, in the cycle after the sixth write.
- R4: The same five-write prefix followed by 40@5555 raises `lock_start_o` for one cycle, in the cycle after the sixth write.
- R5: The writes AA@5555, 55@2AAA and 90@5555 set `id_mode_o` in the cycle after the third write.
- R6: A write of F0 clears `id_mode_o` in the next cycle and returns the decoder to idle. This holds whether the F0 is the third write after the prefix (F0@5555) or a lone write to any address.
- R7: With `rd_en_i`=1 and `id_mode_o`=1, address 0 gives `id_hit_o`=1 and `id_data_o`=0x1F, and address 1 gives `id_hit_o`=1 and `id_data_o`=0x22. Any other address, or `id_mode_o`=0, gives `id_hit_o`=0 and `id_data_o`=0.
- R8: A write that does not match the address and data expected at the current step returns the decoder to idle and issues nothing. A new command must start again from AA@5555.
- R9: A write with `busy_i`=1 is ignored. It issues no command and does not advance or reset the sequence in progress.
- R10: At most one of the three start pulses is high in any cycle, and none stays high for two consecutive cycles.
- R11: The data write of a byte program is never decoded as a command. Programming the value F0 leaves `id_mode_o` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Bus write strobe, one cycle per write |
| busy_i | input | 1 | Array sequencer busy |
| addr_i | input | 20 | Bus address for writes and identification reads |
| wdata_i | input | 8 | Bus write data |
| rd_en_i | input | 1 | Bus read strobe |
| prog_start_o | output | 1 | Byte program start pulse |
| prog_addr_o | output | 20 | Byte program target address |
| prog_data_o | output | 8 | Byte program data |
| erase_start_o | output | 1 | Whole-array erase start pulse |
| lock_start_o | output | 1 | Boot-region lock start pulse |
| id_mode_o | output | 1 | Identification mode active |
| id_hit_o | output | 1 | Identification read returns a code |
| id_data_o | output | 8 | Identification code |

## Verification
The hardest states to reach are the ones where a sequence is broken part-way. Examples are a busy-masked write landing between two unlock writes, or a wrong byte at the fifth step of the erase path. The same holds for an F0 that arrives as program data rather than as a command. Directed sequences build each of these cases on purpose. A long stretch of biased random writes follows, drawn mostly from the unlock addresses and command bytes with busy toggled at random. This drives many partial and overlapping prefixes, and a behavioural model that keeps the written history in a queue is compared against all outputs on every cycle.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;
  typedef enum logic [2:0] {
    S_IDLE, S_UNL1, S_UNL2, S_PROG, S_ERA3, S_ERA4, S_ERA5
  } seq_state_e;

  typedef enum logic [2:0] {
    CMD_NONE, CMD_PROG, CMD_ERASE, CMD_LOCK, CMD_ID_ENTER, CMD_ID_EXIT
  } cmd_e;

  localparam logic [7:0] KEY_FIRST  = 8'hAA;
  localparam logic [7:0] KEY_SECOND = 8'h55;
  localparam logic [7:0] OP_PROG    = 8'hA0;
  localparam logic [7:0] OP_SETUP   = 8'h80;
  localparam logic [7:0] OP_ID      = 8'h90;
  localparam logic [7:0] OP_EXIT    = 8'hF0;
  localparam logic [7:0] OP_ERASE   = 8'h10;
  localparam logic [7:0] OP_LOCK    = 8'h40;
endpackage

// File: rtl/flash_cmd_match.sv
module flash_cmd_match #(
  parameter int ADDR_W = 20,
  parameter int DATA_W = 8,
  parameter logic [ADDR_W-1:0] UNL_A = 20'h05555,
  parameter logic [ADDR_W-1:0] UNL_B = 20'h02AAA
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] data_i,
  output logic              at_a_o,
  output logic              key1_o,
  output logic              key2_o,
  output logic              op_prog_o,
  output logic              op_setup_o,
  output logic              op_id_o,
  output logic              op_exit_o,
  output logic              op_erase_o,
  output logic              op_lock_o
);
  import flash_cmd_pkg::*;

  logic at_b;
  assign at_a_o     = (addr_i == UNL_A);
  assign at_b       = (addr_i == UNL_B);
  assign key1_o     = at_a_o && (data_i[7:0] == KEY_FIRST);
  assign key2_o     = at_b && (data_i[7:0] == KEY_SECOND);
  assign op_prog_o  = (data_i[7:0] == OP_PROG);
  assign op_setup_o = (data_i[7:0] == OP_SETUP);
  assign op_id_o    = (data_i[7:0] == OP_ID);
  assign op_exit_o  = (data_i[7:0] == OP_EXIT);
  assign op_erase_o = (data_i[7:0] == OP_ERASE);
  assign op_lock_o  = (data_i[7:0] == OP_LOCK);
endmodule

// File: rtl/flash_cmd_fsm.sv
module flash_cmd_fsm (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       wr_en_i,
  input  logic                       busy_i,
  input  logic                       at_a_i,
  input  logic                       key1_i,
  input  logic                       key2_i,
  input  logic                       op_prog_i,
  input  logic                       op_setup_i,
  input  logic                       op_id_i,
  input  logic                       op_exit_i,
  input  logic                       op_erase_i,
  input  logic                       op_lock_i,
  output flash_cmd_pkg::cmd_e        cmd_o,
  output flash_cmd_pkg::seq_state_e  state_o
);
  import flash_cmd_pkg::*;

  seq_state_e state_q, state_d;
  logic       wr_ok;

  assign wr_ok = wr_en_i && !busy_i;

  always_comb begin
    state_d = state_q;
    cmd_o   = CMD_NONE;
    if (wr_ok) begin
      state_d = S_IDLE;
      if (state_q == S_PROG) begin
        cmd_o = CMD_PROG;                  // data cycle: never decoded
      end else if (op_exit_i) begin
        cmd_o = CMD_ID_EXIT;               // escape from any step
      end else begin
        unique case (state_q)
          S_IDLE: if (key1_i) state_d = S_UNL1;
          S_UNL1: if (key2_i) state_d = S_UNL2;
          S_UNL2: if (at_a_i) begin
            if (op_prog_i)       state_d = S_PROG;
            else if (op_setup_i) state_d = S_ERA3;
            else if (op_id_i)    cmd_o   = CMD_ID_ENTER;
          end
          S_ERA3: if (key1_i) state_d = S_ERA4;
          S_ERA4: if (key2_i) state_d = S_ERA5;
          S_ERA5: if (at_a_i) begin
            if (op_erase_i)     cmd_o = CMD_ERASE;
            else if (op_lock_i) cmd_o = CMD_LOCK;
          end
          default: state_d = S_IDLE;
        endcase
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= S_IDLE;
    else         state_q <= state_d;
  end

  assign state_o = state_q;

  a_r9_hold_when_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_i |=> $stable(state_q));
  a_r2_prog_step_order: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == S_PROG) |-> ($past(state_q) inside {S_UNL2, S_PROG}));
  a_r3_era5_order: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == S_ERA5) |-> ($past(state_q) inside {S_ERA4, S_ERA5}));
  a_r8_unl1_from_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == S_UNL1) |-> ($past(state_q) inside {S_IDLE, S_UNL1}));
endmodule

// File: rtl/flash_id_rom.sv
module flash_id_rom #(
  parameter int ADDR_W = 20,
  parameter int DATA_W = 8,
  parameter logic [DATA_W-1:0] MFG_CODE = 8'h1F,
  parameter logic [DATA_W-1:0] DEV_CODE = 8'h22
) (
  input  logic              id_mode_i,
  input  logic              rd_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic              hit_o,
  output logic [DATA_W-1:0] data_o
);
  localparam int CODE_N = 2;
  logic [DATA_W-1:0] codes [CODE_N];
  assign codes[0] = MFG_CODE;
  assign codes[1] = DEV_CODE;

  logic in_range;
  assign in_range = (addr_i[ADDR_W-1:1] == '0);
  assign hit_o    = id_mode_i && rd_en_i && in_range;
  assign data_o   = hit_o ? codes[addr_i[0]] : '0;
endmodule

// File: rtl/flash_cmd_decoder.sv
module flash_cmd_decoder #(
  parameter int ADDR_W = 20,
  parameter int DATA_W = 8,
  parameter logic [ADDR_W-1:0] UNL_A = 20'h05555,
  parameter logic [ADDR_W-1:0] UNL_B = 20'h02AAA,
  parameter logic [DATA_W-1:0] MFG_CODE = 8'h1F,
  parameter logic [DATA_W-1:0] DEV_CODE = 8'h22
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic              busy_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              rd_en_i,
  output logic              prog_start_o,
  output logic [ADDR_W-1:0] prog_addr_o,
  output logic [DATA_W-1:0] prog_data_o,
  output logic              erase_start_o,
  output logic              lock_start_o,
  output logic              id_mode_o,
  output logic              id_hit_o,
  output logic [DATA_W-1:0] id_data_o
);
  import flash_cmd_pkg::*;

  logic at_a, key1, key2, op_prog, op_setup, op_id, op_exit, op_erase, op_lock;
  cmd_e       cmd;
  seq_state_e state;

  flash_cmd_match #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .UNL_A(UNL_A), .UNL_B(UNL_B)) u_match (
    .addr_i(addr_i), .data_i(wdata_i), .at_a_o(at_a), .key1_o(key1), .key2_o(key2),
    .op_prog_o(op_prog), .op_setup_o(op_setup), .op_id_o(op_id), .op_exit_o(op_exit),
    .op_erase_o(op_erase), .op_lock_o(op_lock)
  );

  flash_cmd_fsm u_fsm (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_en_i(wr_en_i), .busy_i(busy_i),
    .at_a_i(at_a), .key1_i(key1), .key2_i(key2), .op_prog_i(op_prog),
    .op_setup_i(op_setup), .op_id_i(op_id), .op_exit_i(op_exit),
    .op_erase_i(op_erase), .op_lock_i(op_lock), .cmd_o(cmd), .state_o(state)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prog_start_o  <= 1'b0;
      erase_start_o <= 1'b0;
      lock_start_o  <= 1'b0;
      id_mode_o     <= 1'b0;
      prog_addr_o   <= '0;
      prog_data_o   <= '0;
    end else begin
      prog_start_o  <= (cmd == CMD_PROG);
      erase_start_o <= (cmd == CMD_ERASE);
      lock_start_o  <= (cmd == CMD_LOCK);
      if (cmd == CMD_ID_ENTER)     id_mode_o <= 1'b1;
      else if (cmd == CMD_ID_EXIT) id_mode_o <= 1'b0;
      if (cmd == CMD_PROG) begin
        prog_addr_o <= addr_i;
        prog_data_o <= wdata_i;
      end
    end
  end

  flash_id_rom #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .MFG_CODE(MFG_CODE), .DEV_CODE(DEV_CODE)) u_id (
    .id_mode_i(id_mode_o), .rd_en_i(rd_en_i), .addr_i(addr_i),
    .hit_o(id_hit_o), .data_o(id_data_o)
  );

  a_r10_onehot_start: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({prog_start_o, erase_start_o, lock_start_o}));
  a_r10_prog_one_cycle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    prog_start_o |=> !prog_start_o);
  a_r9_busy_no_start: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_i |=> !(prog_start_o || erase_start_o || lock_start_o));
  a_r7_hit_needs_mode: assert property (@(posedge clk_i) disable iff (!rst_ni)
    id_hit_o |-> id_mode_o);
  a_r6_exit_clears_mode: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && !busy_i && wdata_i == OP_EXIT && state != S_PROG) |=> !id_mode_o);
  a_r11_prog_keeps_mode: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && !busy_i && state == S_PROG) |=> $stable(id_mode_o));
endmodule

// File: tb/flash_cmd_decoder_bench.sv
module flash_cmd_decoder_bench;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        wr_en = 0, busy = 0, rd_en = 0;
  logic [19:0] addr = '0;
  logic [7:0]  wdata = '0;
  logic        prog_start, erase_start, lock_start, id_mode, id_hit;
  logic [19:0] prog_addr;
  logic [7:0]  prog_data, id_data;

  always #2 clk = ~clk;

  flash_cmd_decoder u_flash_cmd_decoder (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .busy_i(busy), .addr_i(addr),
    .wdata_i(wdata), .rd_en_i(rd_en), .prog_start_o(prog_start), .prog_addr_o(prog_addr),
    .prog_data_o(prog_data), .erase_start_o(erase_start), .lock_start_o(lock_start),
    .id_mode_o(id_mode), .id_hit_o(id_hit), .id_data_o(id_data)
  );

  int checks = 0, errors = 0;
  bit done = 0;
  int n_prog = 0, n_erase = 0, n_lock = 0;
  logic [19:0] last_paddr;
  logic [7:0]  last_pdata;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // reference model: history of accepted writes
  logic [27:0] seq[$];
  bit e_prog, e_erase, e_lock, e_id;
  logic [19:0] e_paddr;
  logic [7:0]  e_pdata, op;
  int n;

  function automatic bit step_ok(int pos, logic [19:0] a, logic [7:0] d, logic [7:0] o);
    case (pos)
      1: return a == 20'h05555 && d == 8'hAA;
      2: return a == 20'h02AAA && d == 8'h55;
      3: return a == 20'h05555 && (d == 8'hA0 || d == 8'h80 || d == 8'h90);
      4: return o == 8'h80 && a == 20'h05555 && d == 8'hAA;
      5: return a == 20'h02AAA && d == 8'h55;
      6: return a == 20'h05555 && (d == 8'h10 || d == 8'h40);
      default: return 0;
    endcase
  endfunction

  always @(posedge clk or negedge rst_n) begin
    e_prog = 0; e_erase = 0; e_lock = 0;
    if (!rst_n) begin
      seq.delete(); e_id = 0;
    end else if (wr_en && !busy) begin
      seq.push_back({addr, wdata});
      n  = seq.size();
      op = (n >= 3) ? seq[2][7:0] : 8'h00;
      if (n == 4 && op == 8'hA0) begin
        e_prog = 1; e_paddr = addr; e_pdata = wdata; seq.delete();
      end else if (wdata == 8'hF0) begin
        e_id = 0; seq.delete();
      end else if (!step_ok(n, addr, wdata, op)) begin
        seq.delete();
      end else if (n == 3 && wdata == 8'h90) begin
        e_id = 1; seq.delete();
      end else if (n == 6) begin
        if (wdata == 8'h10) e_erase = 1; else e_lock = 1;
        seq.delete();
      end
    end
  end

  // per-cycle comparison, away from the clock edge
  always @(negedge clk) begin
    #1;
    if (rst_n && !done) begin
      bit e_hit;
      e_hit = rd_en && e_id && (addr == 20'd0 || addr == 20'd1);
      chk(prog_start == e_prog, "R2 R10 prog_start", prog_start, e_prog);
      if (e_prog) begin
        chk(prog_addr == e_paddr, "R2 prog_addr", prog_addr, e_paddr);
        chk(prog_data == e_pdata, "R2 prog_data", prog_data, e_pdata);
      end
      chk(erase_start == e_erase, "R3 R10 erase_start", erase_start, e_erase);
      chk(lock_start == e_lock, "R4 R10 lock_start", lock_start, e_lock);
      chk(id_mode == e_id, "R5 R6 id_mode", id_mode, e_id);
      chk(id_hit == e_hit, "R7 id_hit", id_hit, e_hit);
      chk(id_data == (e_hit ? (addr[0] ? 8'h22 : 8'h1F) : 8'h00), "R7 id_data", id_data,
          e_hit ? (addr[0] ? 8'h22 : 8'h1F) : 8'h00);
      if (prog_start) begin n_prog++; last_paddr = prog_addr; last_pdata = prog_data; end
      if (erase_start) n_erase++;
      if (lock_start)  n_lock++;
    end
  end

  task automatic drive(input bit w, input bit b, input bit r, input logic [19:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = w; busy = b; rd_en = r; addr = a; wdata = d;
  endtask
  task automatic wr(input logic [19:0] a, input logic [7:0] d);
    drive(1, 0, 0, a, d);
  endtask
  task automatic idle(int k);
    for (int i = 0; i < k; i++) drive(0, 0, 0, '0, '0);
  endtask
  task automatic unlock();
    wr(20'h05555, 8'hAA); wr(20'h02AAA, 8'h55);
  endtask
  task automatic rd(input logic [19:0] a);
    drive(0, 0, 1, a, '0);
  endtask

  initial begin
    #(200000 * 4);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int p0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk); #1;
    // R1 reset state
    chk(!id_mode && !prog_start && !erase_start && !lock_start, "R1 reset outputs",
        {id_mode, prog_start, erase_start, lock_start}, 0);

    // R2 program
    p0 = n_prog;
    unlock(); wr(20'h05555, 8'hA0); wr(20'h12345, 8'h3C); idle(2);
    chk(n_prog == p0 + 1, "R2 prog count", n_prog, p0 + 1);
    chk(last_paddr == 20'h12345 && last_pdata == 8'h3C, "R2 prog target", last_paddr, 20'h12345);

    // R3 erase, R4 lock
    unlock(); wr(20'h05555, 8'h80); unlock(); wr(20'h05555, 8'h10); idle(2);
    chk(n_erase == 1, "R3 erase count", n_erase, 1);
    unlock(); wr(20'h05555, 8'h80); unlock(); wr(20'h05555, 8'h40); idle(2);
    chk(n_lock == 1, "R4 lock count", n_lock, 1);

    // R5 entry, R7 reads, R11 program F0, R6 exits
    unlock(); wr(20'h05555, 8'h90); idle(1);
    chk(id_mode == 1, "R5 id entered", id_mode, 1);
    rd(20'd0); #1 chk(id_hit && id_data == 8'h1F, "R7 mfg code", id_data, 8'h1F);
    rd(20'd1); #1 chk(id_hit && id_data == 8'h22, "R7 dev code", id_data, 8'h22);
    rd(20'd2); #1 chk(!id_hit && id_data == 8'h00, "R7 other addr", id_data, 0);
    unlock(); wr(20'h05555, 8'hA0); wr(20'h00400, 8'hF0); idle(2);
    chk(id_mode == 1, "R11 program F0 keeps mode", id_mode, 1);
    unlock(); wr(20'h05555, 8'hF0); idle(1);
    chk(id_mode == 0, "R6 three-cycle exit", id_mode, 0);
    unlock(); wr(20'h05555, 8'h90); wr(20'h00777, 8'hF0); idle(1);
    chk(id_mode == 0, "R6 single write exit", id_mode, 0);
    rd(20'd0); #1 chk(!id_hit, "R7 no code outside mode", id_hit, 0);

    // R8 mismatches
    p0 = n_prog;
    unlock(); wr(20'h05554, 8'hA0); wr(20'h00100, 8'h33); idle(2);
    chk(n_prog == p0, "R8 wrong address at step 3", n_prog, p0);
    unlock(); wr(20'h05555, 8'h80); wr(20'h05555, 8'hAA); wr(20'h02AAB, 8'h55);
    wr(20'h05555, 8'h10); idle(2);
    chk(n_erase == 1, "R8 broken erase path", n_erase, 1);

    // R9 busy write inside a sequence
    p0 = n_prog;
    unlock(); drive(1, 1, 0, 20'h00000, 8'h00); wr(20'h05555, 8'hA0);
    drive(1, 1, 0, 20'h05555, 8'h90); wr(20'h00020, 8'h5A); idle(2);
    chk(n_prog == p0 + 1 && last_paddr == 20'h00020, "R9 busy writes ignored", n_prog, p0 + 1);

    // R1 reset mid sequence
    p0 = n_prog;
    unlock(); wr(20'h05555, 8'hA0);
    @(negedge clk); wr_en = 0; rst_n = 0;
    @(negedge clk); rst_n = 1;
    wr(20'h00030, 8'h11); idle(2);
    chk(n_prog == p0, "R1 reset cancels sequence", n_prog, p0);

    // biased random
    for (int i = 0; i < 4000; i++) begin
      logic [19:0] a; logic [7:0] d; int s;
      s = $urandom_range(0, 3);
      a = (s == 0) ? 20'h05555 : (s == 1) ? 20'h02AAA : (s == 2) ? 20'h05555 : 20'($urandom);
      s = $urandom_range(0, 9);
      case (s)
        0, 1: d = 8'hAA; 2, 3: d = 8'h55; 4: d = 8'hA0; 5: d = 8'h80;
        6: d = 8'h90; 7: d = 8'h10; 8: d = 8'h40; default: d = ($urandom_range(0, 3) == 0) ? 8'hF0 : 8'($urandom);
      endcase
      if ($urandom_range(0, 4) == 0) drive(0, 0, 1, 20'($urandom_range(0, 3)), '0);
      else drive($urandom_range(0, 3) != 0, $urandom_range(0, 7) == 0, 0, a, d);
    end
    idle(3);
    chk(n_prog > 0 || n_erase > 0, "R2 R3 random activity", n_prog + n_erase, 1);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule